// File: doc/BRIEF.md
# VLAN Table Command Engine

This block holds the VLAN membership table of a small switch and runs the commands that maintain it. A host reaches the block through a plain synchronous register port. It places a VLAN identifier, per-port data and a database number in registers, then writes the operation register with the go bit set. The engine raises busy and carries out the command. The host polls busy until it clears and then reads back any result from the same registers.

There are three commands. Load/purge installs, replaces or removes the entry for one VID. Get-next finds the lowest stored VID that is strictly above the VID register and copies that entry into the registers. Because the result overwrites the VID register, repeated get-next commands walk the whole table in ascending order. Flush invalidates every entry. Each entry holds a 13-bit VID, an 8-bit database number and a 2-bit membership code plus a 2-bit port state for each port. The table is searched one slot per clock. Identifiers are held in flops and per-entry payloads in a RAM with a registered read.

Top module: `vtab_engine`

## Requirements
- R1: After reset every register reads zero, busy is clear and the table is empty, so a get-next from VID 0 misses.
- R2: Register 1 holds the VID. Bits [11:0] are VID bits 11..0, bit 13 is VID bit 12, bit 12 is the entry-valid flag, and bits [15:14] read zero.
- R3: Registers 2, 3 and 4 carry the port fields. Port i uses register 2+i/4 at bit offset (i mod 4)*4, with the membership code in the low two bits of that slot and the port state in the high two bits. Bits above the last port read zero.
- R4: Register 0 is the operation register. Bit 15 is go/busy and bits [14:12] are the opcode (1 flush, 3 load/purge, 4 get-next). Database bits [3:0] sit in [3:0] and database bits [7:4] sit in [11:8]. Bit 7 is a read-only full flag. A write with bit 15 set and a known opcode starts that command.
- R5: Busy reads 1 from the cycle after a command starts until the command ends. A command ends within DEPTH+3 cycles.
- R6: Load with the valid flag set writes the entry for that VID from the port and database fields, or replaces it if that VID is already stored.
- R7: Load with the valid flag clear removes the entry for that VID.
- R8: Get-next returns the lowest stored VID strictly greater than the VID register. It writes that VID, valid=1, the port fields and the database number into the registers.
- R9: Get-next issued again without rewriting the VID register steps to the next higher entry.
- R10: A get-next with no higher entry sets the VID register to 0x1FFF with valid clear and leaves the port fields unchanged.
- R11: A load of a new VID into a full table is dropped and sets the full flag. Replacing an existing VID still works. The flag stays set until a flush.
- R12: Flush removes every entry and clears the full flag.
- R13: Host writes to any register are ignored while busy is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |

## Verification
The assertions assume the host follows the polling rule. A command word arrives only when busy is clear, and any write made during busy is treated as a stray that must leave the registers untouched. The bench starts every command only after it has read busy as zero. It deliberately writes into the VID and port registers while a search is running to exercise the ignore path. It never stores the same VID twice except through the replace path.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam int VID_W  = 13;
  localparam int DB_W   = 8;
  localparam int REG_W  = 16;
  localparam int SLOT_W = 4;

  localparam logic [2:0] OP_FLUSH = 3'd1;
  localparam logic [2:0] OP_LOAD  = 3'd3;
  localparam logic [2:0] OP_NEXT  = 3'd4;

  localparam logic [VID_W-1:0] VID_NONE = 13'h1FFF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FLUSH,
    S_SCAN,
    S_END,
    S_FETCH
  } seq_state_t;
endpackage

// File: rtl/vtab_regs.sv
module vtab_regs
  import vtab_pkg::*;
#(
  parameter int NPORTS = 11,
  parameter int NREGS  = 3,
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [REG_W-1:0]       wr_data,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [REG_W-1:0]       rd_data,
  input  logic                   busy,
  input  logic                   res_we,
  input  logic                   res_hit,
  input  logic [VID_W-1:0]       res_vid,
  input  logic [DB_W-1:0]        res_db,
  input  logic [NREGS*REG_W-1:0] res_data,
  input  logic                   set_full,
  input  logic                   flush_go,
  output logic [VID_W-1:0]       key_vid,
  output logic                   key_valid,
  output logic [DB_W-1:0]        cur_db,
  output logic [NREGS*REG_W-1:0] cur_data,
  output logic                   full,
  output logic                   start,
  output logic [2:0]             start_op
);
  localparam int DATA_BITS = NPORTS * SLOT_W;
  localparam int TOT_BITS  = NREGS * REG_W;
  localparam logic [TOT_BITS-1:0] DATA_MASK = {TOT_BITS{1'b1}} >> (TOT_BITS - DATA_BITS);

  logic [11:0]         vid_lo;
  logic                vid_page;
  logic                vid_valid;
  logic [2:0]          opc_q;
  logic [DB_W-1:0]     db_q;
  logic [TOT_BITS-1:0] data_q;
  logic                full_q;
  logic                host_ok;
  logic [REG_W-1:0]    rd_mux;

  assign host_ok  = wr_en && !busy;
  assign start_op = wr_data[14:12];
  assign start    = host_ok && (wr_addr == '0) && wr_data[15] &&
                    (start_op == OP_FLUSH || start_op == OP_LOAD || start_op == OP_NEXT);

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_lo    <= '0;
      vid_page  <= 1'b0;
      vid_valid <= 1'b0;
      opc_q     <= '0;
      db_q      <= '0;
      data_q    <= '0;
      full_q    <= 1'b0;
    end else begin
      if (host_ok) begin
        if (wr_addr == ADDR_W'(0)) begin
          opc_q <= wr_data[14:12];
          db_q  <= {wr_data[11:8], wr_data[3:0]};
        end
        if (wr_addr == ADDR_W'(1)) begin
          vid_lo    <= wr_data[11:0];
          vid_valid <= wr_data[12];
          vid_page  <= wr_data[13];
        end
        for (int r = 0; r < NREGS; r++) begin
          if (wr_addr == ADDR_W'(r + 2))
            data_q[r*REG_W +: REG_W] <= wr_data & DATA_MASK[r*REG_W +: REG_W];
        end
      end
      if (res_we) begin
        if (res_hit) begin
          {vid_page, vid_lo} <= res_vid;
          vid_valid          <= 1'b1;
          data_q             <= res_data & DATA_MASK;
          db_q               <= res_db;
        end else begin
          {vid_page, vid_lo} <= VID_NONE;
          vid_valid          <= 1'b0;
        end
      end
      if (flush_go)
        full_q <= 1'b0;
      else if (set_full)
        full_q <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_W'(0))
      rd_mux = {busy, opc_q, db_q[7:4], full_q, 3'b000, db_q[3:0]};
    else if (rd_addr == ADDR_W'(1))
      rd_mux = {2'b00, vid_page, vid_valid, vid_lo};
    for (int r = 0; r < NREGS; r++) begin
      if (rd_addr == ADDR_W'(r + 2))
        rd_mux = data_q[r*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_mux;
  end

  assign key_vid   = {vid_page, vid_lo};
  assign key_valid = vid_valid;
  assign cur_db    = db_q;
  assign cur_data  = data_q;
  assign full      = full_q;
endmodule

// File: rtl/vtab_store.sv
module vtab_store
  import vtab_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = 56,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VID_W-1:0] wr_vid,
  input  logic [PW-1:0]    wr_pl,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] scan_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             scan_vld,
  output logic [VID_W-1:0] scan_vid,
  output logic [PW-1:0]    rd_pl,
  output logic [DEPTH-1:0] vld
);
  logic [VID_W-1:0] vid_tab [DEPTH];
  logic [PW-1:0]    pl_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
    end else begin
      if (wr_en)
        vld[wr_idx] <= 1'b1;
      if (clr_en)
        vld[clr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      vid_tab[wr_idx] <= wr_vid;
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      pl_mem[wr_idx] <= wr_pl;
    rd_pl <= pl_mem[rd_idx];
  end

  assign scan_vld = vld[scan_idx];
  assign scan_vid = vid_tab[scan_idx];
endmodule

// File: rtl/vtab_seq.sv
module vtab_seq
  import vtab_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       start_op,
  input  logic [VID_W-1:0] key_vid,
  input  logic             key_valid,
  input  logic             scan_vld,
  input  logic [VID_W-1:0] scan_vid,
  output logic             busy,
  output logic [IDX_W-1:0] scan_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             flush_go,
  output logic             st_we,
  output logic [IDX_W-1:0] st_idx,
  output logic             st_clr,
  output logic [IDX_W-1:0] clr_idx,
  output logic             res_we,
  output logic             res_hit,
  output logic [VID_W-1:0] res_vid,
  output logic             set_full
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  seq_state_t       state;
  logic [2:0]       op_q;
  logic [IDX_W-1:0] idx;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic             free_ok;
  logic [IDX_W-1:0] free_idx;
  logic             best_ok;
  logic [IDX_W-1:0] best_idx;
  logic [VID_W-1:0] best_vid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op_q     <= '0;
      idx      <= '0;
      hit      <= 1'b0;
      hit_idx  <= '0;
      free_ok  <= 1'b0;
      free_idx <= '0;
      best_ok  <= 1'b0;
      best_idx <= '0;
      best_vid <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            op_q    <= start_op;
            idx     <= '0;
            hit     <= 1'b0;
            free_ok <= 1'b0;
            best_ok <= 1'b0;
            state   <= (start_op == OP_FLUSH) ? S_FLUSH : S_SCAN;
          end
        end
        S_FLUSH: state <= S_IDLE;
        S_SCAN: begin
          if (op_q == OP_LOAD) begin
            if (scan_vld && scan_vid == key_vid) begin
              hit     <= 1'b1;
              hit_idx <= idx;
            end
            if (!scan_vld && !free_ok) begin
              free_ok  <= 1'b1;
              free_idx <= idx;
            end
          end else begin
            if (scan_vld && scan_vid > key_vid && (!best_ok || scan_vid < best_vid)) begin
              best_ok  <= 1'b1;
              best_idx <= idx;
              best_vid <= scan_vid;
            end
          end
          if (idx == LAST)
            state <= S_END;
          else
            idx <= idx + 1'b1;
        end
        S_END:   state <= (op_q == OP_NEXT && best_ok) ? S_FETCH : S_IDLE;
        S_FETCH: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (state != S_IDLE);
    flush_go = (state == S_FLUSH);
    scan_idx = idx;
    rd_idx   = best_idx;
    st_idx   = hit ? hit_idx : free_idx;
    clr_idx  = hit_idx;
    st_we    = 1'b0;
    st_clr   = 1'b0;
    set_full = 1'b0;
    res_we   = 1'b0;
    res_hit  = 1'b0;
    res_vid  = best_vid;
    if (state == S_END) begin
      if (op_q == OP_LOAD) begin
        st_we    = key_valid && (hit || free_ok);
        set_full = key_valid && !hit && !free_ok;
        st_clr   = !key_valid && hit;
      end else begin
        res_we = !best_ok;
      end
    end
    if (state == S_FETCH) begin
      res_we  = 1'b1;
      res_hit = 1'b1;
    end
  end
endmodule

// File: rtl/vtab_engine.sv
module vtab_engine
  import vtab_pkg::*;
#(
  parameter int NPORTS = 11,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data
);
  localparam int NREGS = (NPORTS + 3) / 4;
  localparam int DW    = NREGS * REG_W;
  localparam int PW    = DB_W + DW;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             busy, start, full, flush_go;
  logic [2:0]       start_op;
  logic [VID_W-1:0] key_vid, res_vid, scan_vid;
  logic             key_valid, res_we, res_hit, set_full;
  logic [DB_W-1:0]  cur_db;
  logic [DW-1:0]    cur_data;
  logic [PW-1:0]    rd_pl;
  logic             scan_vld, st_we, st_clr;
  logic [IDX_W-1:0] scan_idx, rd_idx, st_idx, clr_idx;
  logic [DEPTH-1:0] vld;

  vtab_regs #(.NPORTS(NPORTS), .NREGS(NREGS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .res_we(res_we), .res_hit(res_hit), .res_vid(res_vid),
    .res_db(rd_pl[PW-1 -: DB_W]), .res_data(rd_pl[DW-1:0]),
    .set_full(set_full), .flush_go(flush_go),
    .key_vid(key_vid), .key_valid(key_valid), .cur_db(cur_db), .cur_data(cur_data),
    .full(full), .start(start), .start_op(start_op)
  );

  vtab_store #(.DEPTH(DEPTH), .PW(PW), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush_go),
    .wr_en(st_we), .wr_idx(st_idx), .wr_vid(key_vid), .wr_pl({cur_db, cur_data}),
    .clr_en(st_clr), .clr_idx(clr_idx),
    .scan_idx(scan_idx), .rd_idx(rd_idx),
    .scan_vld(scan_vld), .scan_vid(scan_vid), .rd_pl(rd_pl), .vld(vld)
  );

  vtab_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_op(start_op),
    .key_vid(key_vid), .key_valid(key_valid),
    .scan_vld(scan_vld), .scan_vid(scan_vid),
    .busy(busy), .scan_idx(scan_idx), .rd_idx(rd_idx), .flush_go(flush_go),
    .st_we(st_we), .st_idx(st_idx), .st_clr(st_clr), .clr_idx(clr_idx),
    .res_we(res_we), .res_hit(res_hit), .res_vid(res_vid), .set_full(set_full)
  );
endmodule

// File: rtl/vtab_engine_chk.sv
module vtab_engine_chk #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              res_we,
  input logic              res_hit,
  input logic [12:0]       key_vid,
  input logic              key_valid,
  input logic              full,
  input logic              flush_go,
  input logic [DEPTH-1:0]  vld
);
  // R5: an accepted command raises busy on the next cycle
  p_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R13: a VID write during busy leaves the VID register as it was
  p_busy_ignore_r13: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && wr_addr == ADDR_W'(1) && !res_we) |=> ($stable(key_vid) && $stable(key_valid)));

  // R10: a miss leaves all ones and valid clear
  p_miss_ones_r10: assert property (@(posedge clk) disable iff (rst)
    (res_we && !res_hit) |=> (key_vid == 13'h1FFF && !key_valid));

  // R8: a hit marks the VID register valid
  p_hit_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (res_we && res_hit) |=> key_valid);

  // R11: the full flag holds until a flush
  p_full_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (full && !flush_go) |=> full);

  // R12: a flush empties the table and clears the flag
  p_flush_empty_r12: assert property (@(posedge clk) disable iff (rst)
    flush_go |=> (vld == '0 && !full));
endmodule

bind vtab_engine vtab_engine_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .wr_en(wr_en), .wr_addr(wr_addr), .res_we(res_we), .res_hit(res_hit),
  .key_vid(key_vid), .key_valid(key_valid), .full(full),
  .flush_go(flush_go), .vld(vld)
);

// File: tb/tb_vtab_engine.sv
`timescale 1ns/1ps
module tb_vtab_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vtab_engine dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int n = 0; n < 100; n++) begin
      rd(3'd0, v);
      if (!v[15]) return;
    end
    check("R5 busy timeout", 16'h1, 16'h0);
  endtask

  function automatic logic [15:0] op_word(input logic go, input logic [2:0] opc,
                                          input logic [7:0] db, input logic fl);
    return {go, opc, db[7:4], fl, 3'b000, db[3:0]};
  endfunction

  function automatic logic [15:0] vid_word(input logic [12:0] v, input logic valid);
    return {2'b00, v[12], valid, v[11:0]};
  endfunction

  task automatic load(input logic [12:0] v, input logic valid, input logic [7:0] db,
                      input logic [15:0] d0, input logic [15:0] d1, input logic [15:0] d2);
    wr(3'd1, vid_word(v, valid));
    wr(3'd2, d0); wr(3'd3, d1); wr(3'd4, d2);
    wr(3'd0, op_word(1'b1, 3'd3, db, 1'b0));
    wait_idle();
  endtask

  task automatic next_cmd();
    wr(3'd0, op_word(1'b1, 3'd4, 8'h00, 1'b0));
    wait_idle();
  endtask

  task automatic expect_entry(input string req, input logic [12:0] v, input logic [7:0] db,
                              input logic fl, input logic [15:0] d0,
                              input logic [15:0] d1, input logic [15:0] d2);
    logic [15:0] r;
    rd(3'd1, r); check({req, " vid"}, r, vid_word(v, 1'b1));
    rd(3'd0, r); check({req, " op/db"}, r, op_word(1'b0, 3'd4, db, fl));
    rd(3'd2, r); check({req, " data0"}, r, d0);
    rd(3'd3, r); check({req, " data1"}, r, d1);
    rd(3'd4, r); check({req, " data2"}, r, d2);
  endtask

  task automatic expect_miss(input string req);
    logic [15:0] r;
    rd(3'd1, r); check({req, " miss vid"}, r, 16'h2FFF);
  endtask

  task automatic t_reset();
    logic [15:0] r;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r); check("R1 reset reg", r, 16'h0000);
    end
    next_cmd();
    expect_miss("R1");
  endtask

  task automatic t_layout();
    logic [15:0] r;
    wr(3'd1, 16'h3ABC); rd(3'd1, r); check("R2 vid readback", r, 16'h3ABC);
    wr(3'd1, 16'hFFFF); rd(3'd1, r); check("R2 top bits zero", r, 16'h3FFF);
    wr(3'd4, 16'hFFFF); rd(3'd4, r); check("R3 unused port bits", r, 16'h0FFF);
    wr(3'd2, 16'hFFFF); rd(3'd2, r); check("R3 full data reg", r, 16'hFFFF);
    wr(3'd0, 16'h0F8F); rd(3'd0, r); check("R4 db split, no go", r, 16'h0F0F);
  endtask

  task automatic t_walk();
    load(13'h0005, 1'b1, 8'h3C, 16'h1234, 16'h5678, 16'h09AB);
    load(13'h1100, 1'b1, 8'hA5, 16'hFFFF, 16'h0001, 16'h0FFF);
    load(13'h0200, 1'b1, 8'h01, 16'h0000, 16'hC3C3, 16'h0123);
    wr(3'd1, 16'h0000);
    next_cmd(); expect_entry("R8 first", 13'h0005, 8'h3C, 1'b0, 16'h1234, 16'h5678, 16'h09AB);
    next_cmd(); expect_entry("R9 second", 13'h0200, 8'h01, 1'b0, 16'h0000, 16'hC3C3, 16'h0123);
    next_cmd(); expect_entry("R9 third", 13'h1100, 8'hA5, 1'b0, 16'hFFFF, 16'h0001, 16'h0FFF);
    next_cmd(); expect_miss("R10");
    begin
      logic [15:0] r;
      rd(3'd2, r); check("R10 data kept", r, 16'hFFFF);
      rd(3'd4, r); check("R10 data kept", r, 16'h0FFF);
    end
  endtask

  task automatic t_replace_purge();
    load(13'h0200, 1'b1, 8'h77, 16'h1111, 16'h2222, 16'h0333);
    wr(3'd1, vid_word(13'h01FF, 1'b0));
    next_cmd(); expect_entry("R6 replace", 13'h0200, 8'h77, 1'b0, 16'h1111, 16'h2222, 16'h0333);
    load(13'h0005, 1'b0, 8'h00, 16'h0, 16'h0, 16'h0);
    wr(3'd1, 16'h0000);
    next_cmd(); expect_entry("R7 purge", 13'h0200, 8'h77, 1'b0, 16'h1111, 16'h2222, 16'h0333);
  endtask

  task automatic t_busy();
    logic [15:0] r;
    wr(3'd1, vid_word(13'h1100, 1'b1));
    wr(3'd0, op_word(1'b1, 3'd4, 8'h00, 1'b0));
    wr(3'd2, 16'hAAAA);
    wr(3'd1, 16'h0042);
    rd(3'd0, r); check("R5 busy set", {15'd0, r[15]}, 16'h0001);
    wait_idle();
    rd(3'd1, r); check("R13 vid write ignored", r, 16'h2FFF);
    rd(3'd2, r); check("R13 data write ignored", r, 16'h1111);
  endtask

  task automatic t_full();
    logic [15:0] r;
    wr(3'd0, op_word(1'b1, 3'd1, 8'h00, 1'b0)); wait_idle();
    wr(3'd1, 16'h0000);
    next_cmd(); expect_miss("R12 empty after flush");
    for (int k = 0; k < 16; k++)
      load(13'(16 + k), 1'b1, 8'(k), 16'(k), 16'h0, 16'h0);
    rd(3'd0, r); check("R11 not yet full", {15'd0, r[7]}, 16'h0000);
    load(13'h0030, 1'b1, 8'h30, 16'h0, 16'h0, 16'h0);
    rd(3'd0, r); check("R11 full flag", r, op_word(1'b0, 3'd3, 8'h30, 1'b1));
    wr(3'd1, vid_word(13'h002F, 1'b0));
    next_cmd(); expect_miss("R11 dropped");
    load(13'h001F, 1'b1, 8'hEE, 16'h4321, 16'h0, 16'h0);
    wr(3'd1, vid_word(13'h001E, 1'b0));
    next_cmd(); expect_entry("R11 replace when full", 13'h001F, 8'hEE, 1'b1, 16'h4321, 16'h0, 16'h0);
    wr(3'd0, op_word(1'b1, 3'd1, 8'h00, 1'b0)); wait_idle();
    rd(3'd0, r); check("R12 flag cleared", {15'd0, r[7]}, 16'h0000);
    wr(3'd1, 16'h0000);
    next_cmd(); expect_miss("R12 flushed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_layout();
    t_walk();
    t_replace_purge();
    t_busy();
    t_full();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule